// File: doc/BRIEF.md
# Loopback Connector Pin Fault Tester

This block checks a bank of bidirectional I/O pins that a test fixture ties together in fixed pairs. It enables the output driver of exactly one pin at a time. Every other pin stays an input under a shared weak pull, and a single output selects whether that pull is up or down. After a settling window the block samples the whole bank. A pin whose loopback partner fails to follow the drive is marked open. A pin outside the driven pair that follows the drive is marked shorted.

Each pin is tested twice. The first pass runs with pull-ups and drives low. The second pass runs with pull-downs and drives high. A pin stuck at either level therefore appears in the fault vectors. The pairing comes from a parameter, and each entry is an 8-bit partner index. The default pairs pin i with pin i+N/2, so the two halves of a single connector loop onto each other and no pair is physically adjacent. With such a map, a short between neighbouring pins cannot hide inside a loopback pair.

All interfaces are plain control and status pins. The block has no data stream and so no back-pressure. A one-cycle `start` pulse launches a run, and `done` pulses once at the end. The fault vectors then stay valid until the next accepted start.

Top module: `lp_conn_tester`

## Requirements
- R1: At most one bit of `pin_oe` is high in any cycle. All bits are low while idle and during the `done` cycle.
- R2: The drive level is the opposite of the pull level. While `pull_hi`=1 (pull-up phase) the enabled pin outputs 0. While `pull_hi`=0 (pull-down phase) it outputs 1. `pull_hi` is 1 while idle.
- R3: A run has 2N steps. The pull-up phase enables pins 0 to N-1 in ascending order, then the pull-down phase enables pins 0 to N-1 again.
- R4: Each step keeps its enable for SETTLE cycles, with a floor of 16, and samples `pin_in` on the last of them. If `start` is sampled at edge E, `done` is high only in the cycle that follows edge E+2N·SETTLE.
- R5: `open_flag[i]` is set when, during a step that drives pin i (either phase), the partner of pin i does not read the drive level.
- R6: `short_flag[j]` is set when, during any step, pin j is neither the driven pin nor its partner and reads the drive level.
- R7: `done` lasts exactly one cycle. Both fault vectors keep their values until the next accepted start and are cleared by it.
- R8: `start` is accepted only while idle. A strobe during a run or in the `done` cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| pin_in | input | N | Sampled level of every pin |
| pin_oe | output | N | Per-pin output enable, at most one high |
| pin_out | output | N | Per-pin output value |
| pull_hi | output | 1 | 1 selects pull-ups on undriven pins, 0 selects pull-downs |
| done | output | 1 | One-cycle end-of-run pulse |
| open_flag | output | N | Pins whose partner did not follow their drive |
| short_flag | output | N | Pins that followed a drive they are not paired with |

## Verification
The end of the last step and an incoming `start` can fall in the same cycle. The bench raises `start` so that it is sampled in the `done` cycle, right after the final sample has updated the fault vectors. The bench then checks that the faults from the final step are kept, that no pin is enabled afterwards and that no second `done` appears. A `start` raised in the middle of a run is judged the same way: `done` must still arrive at the cycle set by the first strobe.

// File: rtl/lp_tester_pkg.sv
package lp_tester_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } lp_state_e;

  localparam int PART_W = 8;
  localparam int SETTLE_FLOOR = 16;
endpackage

// File: rtl/lp_step_seq.sv
module lp_step_seq
  import lp_tester_pkg::*;
#(
  parameter int N = 8,
  parameter int SETTLE = 16,
  localparam int IW = $clog2(N),
  localparam int SETTLE_EFF = (SETTLE < SETTLE_FLOOR) ? SETTLE_FLOOR : SETTLE,
  localparam int CW = $clog2(SETTLE_EFF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output lp_state_e     state,
  output logic [IW-1:0] idx,
  output logic          phase,
  output logic          sample,
  output logic          clear
);
  localparam logic [CW-1:0] LAST_CNT = CW'(SETTLE_EFF - 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

  logic [CW-1:0] cnt;

  assign sample = (state == ST_RUN) && (cnt == LAST_CNT);
  assign clear  = (state == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      phase <= 1'b0;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            idx   <= '0;
            phase <= 1'b0;
            cnt   <= '0;
          end
        end
        ST_RUN: begin
          if (cnt == LAST_CNT) begin
            cnt <= '0;
            if (idx == LAST_IDX) begin
              idx <= '0;
              if (phase) begin
                state <= ST_DONE;
                phase <= 1'b0;
              end else begin
                phase <= 1'b1;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lp_drive.sv
module lp_drive #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          run,
  input  logic [IW-1:0] idx,
  input  logic          phase,
  output logic [N-1:0]  pin_oe,
  output logic [N-1:0]  pin_out,
  output logic          pull_hi
);
  for (genvar j = 0; j < N; j++) begin : g_pin
    assign pin_oe[j]  = run && (idx == IW'(j));
    assign pin_out[j] = pin_oe[j] && phase;
  end
  assign pull_hi = ~phase;
endmodule

// File: rtl/lp_judge.sv
module lp_judge
  import lp_tester_pkg::*;
#(
  parameter int N = 8,
  parameter logic [N*PART_W-1:0] PARTNER = '0,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sample,
  input  logic [IW-1:0] idx,
  input  logic          phase,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  open_flag,
  output logic [N-1:0]  short_flag
);
  logic [IW-1:0] pidx;
  logic [N-1:0]  open_n, short_n;

  assign pidx = PARTNER[idx*PART_W +: IW];

  always_comb begin
    open_n  = open_flag;
    short_n = short_flag;
    if (clear) begin
      open_n  = '0;
      short_n = '0;
    end else if (sample) begin
      if (pin_in[pidx] != phase) open_n[idx] = 1'b1;
      for (int j = 0; j < N; j++) begin
        if ((IW'(j) != idx) && (IW'(j) != pidx) && (pin_in[j] == phase))
          short_n[j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_flag  <= '0;
      short_flag <= '0;
    end else begin
      open_flag  <= open_n;
      short_flag <= short_n;
    end
  end
endmodule

// File: rtl/lp_conn_tester.sv
module lp_conn_tester
  import lp_tester_pkg::*;
#(
  parameter int N = 8,
  parameter int SETTLE = 16,
  parameter logic [N*PART_W-1:0] PARTNER =
    {8'd3, 8'd2, 8'd1, 8'd0, 8'd7, 8'd6, 8'd5, 8'd4}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_oe,
  output logic [N-1:0] pin_out,
  output logic         pull_hi,
  output logic         done,
  output logic [N-1:0] open_flag,
  output logic [N-1:0] short_flag
);
  localparam int IW = $clog2(N);

  lp_state_e     state;
  logic [IW-1:0] idx;
  logic          phase, sample, clear;

  lp_step_seq #(.N(N), .SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .state(state),
    .idx(idx), .phase(phase), .sample(sample), .clear(clear)
  );

  lp_drive #(.N(N)) u_drv (
    .run(state == ST_RUN), .idx(idx), .phase(phase),
    .pin_oe(pin_oe), .pin_out(pin_out), .pull_hi(pull_hi)
  );

  lp_judge #(.N(N), .PARTNER(PARTNER)) u_judge (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sample(sample),
    .idx(idx), .phase(phase), .pin_in(pin_in),
    .open_flag(open_flag), .short_flag(short_flag)
  );

  assign done = (state == ST_DONE);
endmodule

// File: rtl/lp_conn_tester_chk.sv
module lp_conn_tester_chk #(
  parameter int N = 8,
  parameter int MIN_HOLD = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] pin_oe,
  input logic [N-1:0] pin_out,
  input logic         pull_hi,
  input logic         done,
  input logic [N-1:0] open_flag,
  input logic [N-1:0] short_flag
);
  logic [N-1:0] prev_oe;
  logic [7:0]   hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_oe <= '0;
      hold    <= '0;
    end else begin
      prev_oe <= pin_oe;
      if (pin_oe != prev_oe) hold <= '0;
      else if (hold != 8'hFF) hold <= hold + 8'd1;
    end
  end

  // R1
  oe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pin_oe));

  // R1
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pin_oe == '0));

  // R2
  drive_vs_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != '0) |-> (((pin_out & pin_oe) != '0) == !pull_hi));

  // R3
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != '0 && prev_oe != '0 && pin_oe != prev_oe) |->
      ((pin_oe == (prev_oe << 1)) || (prev_oe[N-1] && pin_oe[0])));

  // R4
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_oe != '0 && pin_oe != prev_oe) |-> (32'(hold) + 1 >= MIN_HOLD));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  faults_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(open_flag) && $stable(short_flag)));
endmodule

bind lp_conn_tester lp_conn_tester_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_oe(pin_oe), .pin_out(pin_out),
  .pull_hi(pull_hi), .done(done), .open_flag(open_flag),
  .short_flag(short_flag)
);

// File: tb/tb_lp_conn_tester.sv
module tb_lp_conn_tester;
  localparam int N = 8;
  localparam int STEP = 16;
  localparam int RUN_LEN = 2 * N * STEP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] pin_in, pin_oe, pin_out, open_flag, short_flag;
  logic pull_hi, done;

  logic [N-1:0] cut = '0;
  int  sa = 0, sb = 0, st = 0;
  bit  sh_en = 0, st_en = 0;
  logic st_val = 1'b0;

  int vecs = 0, errs = 0, cyc = 0;

  always #4 clk = ~clk;

  lp_conn_tester dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pull_hi(pull_hi), .done(done),
    .open_flag(open_flag), .short_flag(short_flag)
  );

  function automatic logic [N-1:0] fixture(
    logic [N-1:0] oe, logic [N-1:0] ov, logic pu, logic [N-1:0] c,
    int a, int b, bit she, int s, bit se, logic sv);
    int lab [N];
    logic [N-1:0] r;
    for (int j = 0; j < N; j++) lab[j] = j;
    for (int it = 0; it < N; it++) begin
      for (int j = 0; j < N; j++) begin
        int p = (j + N/2) % N;
        if (!c[j] && !c[p]) begin
          int m = (lab[j] < lab[p]) ? lab[j] : lab[p];
          lab[j] = m; lab[p] = m;
        end
      end
      if (she) begin
        int m = (lab[a] < lab[b]) ? lab[a] : lab[b];
        lab[a] = m; lab[b] = m;
      end
    end
    for (int j = 0; j < N; j++) begin
      r[j] = pu;
      for (int k = 0; k < N; k++)
        if (lab[k] == lab[j] && oe[k]) r[j] = ov[k];
      if (se && lab[s] == lab[j]) r[j] = sv;
    end
    return r;
  endfunction

  assign pin_in = fixture(pin_oe, pin_out, pull_hi, cut, sa, sb, sh_en, st, st_en, st_val);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic set_fixture(input logic [N-1:0] c, input bit she, input int a, input int b,
                             input bit se, input int s, input logic sv);
    cut = c; sh_en = she; sa = a; sb = b; st_en = se; st = s; st_val = sv;
  endtask

  // One run: start, optional per-step checks, optional strobes mid-run / on done.
  task automatic run(input bit step_chk, input bit mid_start, input bit done_start,
                     input bit clr_chk, input logic [N-1:0] exp_open, input logic [N-1:0] exp_short);
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    if (clr_chk) begin
      // R7 faults cleared by accepted start
      chk(open_flag == '0 && short_flag == '0, "R7 clear on start", {open_flag, short_flag}, 0);
    end
    for (int k = 1; k <= RUN_LEN; k++) begin
      @(negedge clk);
      start = mid_start && (k == 100);
      if (step_chk && ((k - 1) % STEP) == 8) begin
        int s = (k - 1) / STEP;
        logic [N-1:0] eoe = N'(1) << (s % N);
        chk(pin_oe == eoe, "R1 R3 step enable", pin_oe, eoe);
        chk(pull_hi == (s < N), "R2 pull phase", pull_hi, (s < N));
        chk(pin_out == ((s < N) ? '0 : eoe), "R2 drive level", pin_out, (s < N) ? '0 : eoe);
      end
      if (k == RUN_LEN) chk(done == 1'b0, "R4 done not early", done, 0);
      @(posedge clk);
    end
    #1;
    chk(done == 1'b1, "R4 done timing", done, 1);
    chk(pin_oe == '0, "R1 idle enables at done", pin_oe, 0);
    chk(open_flag == exp_open, "R5 open vector", open_flag, exp_open);
    chk(short_flag == exp_short, "R6 short vector", short_flag, exp_short);
    if (done_start) start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    if (done_start) begin
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (pin_oe != '0 || done) begin
          chk(0, "R8 start on done cycle ignored", {pin_oe, 7'd0, done}, 0);
          break;
        end
      end
      chk(open_flag == exp_open && short_flag == exp_short, "R8 faults kept after done strobe",
          {open_flag, short_flag}, {exp_open, exp_short});
    end
  endtask

  task automatic t_reset();
    #1;
    chk(pin_oe == '0 && pin_out == '0, "R1 reset enables", {pin_oe, pin_out}, 0);
    chk(pull_hi == 1'b1, "R2 reset pull", pull_hi, 1);
    chk(done == 1'b0, "R7 reset done", done, 0);
    chk(open_flag == '0 && short_flag == '0, "R5 R6 reset faults", {open_flag, short_flag}, 0);
  endtask

  task automatic t_clean();
    set_fixture('0, 0, 0, 0, 0, 0, 1'b0);
    run(1, 0, 0, 0, '0, '0);
  endtask

  task automatic t_open();
    set_fixture(8'h02, 0, 0, 0, 0, 0, 1'b0);   // R5 broken link 1<->5
    run(0, 0, 0, 0, 8'h22, 8'h00);
  endtask

  task automatic t_short();
    set_fixture('0, 1, 2, 3, 0, 0, 1'b0);      // R6 neighbours 2,3 shorted
    run(0, 0, 0, 0, 8'h00, 8'hCC);
  endtask

  task automatic t_stuck_hi();
    set_fixture('0, 0, 0, 0, 1, 0, 1'b1);      // R5 R6 pin 0 stuck high
    run(0, 0, 0, 0, 8'h11, 8'h11);
  endtask

  task automatic t_stuck_lo_done_start();
    set_fixture('0, 0, 0, 0, 1, 6, 1'b0);      // R5 R6 pin 6 stuck low, R8 strobe on done
    run(0, 0, 1, 0, 8'h44, 8'h44);
  endtask

  task automatic t_hold_then_clear();
    repeat (30) @(posedge clk);
    #1 chk(open_flag == 8'h44 && short_flag == 8'h44, "R7 faults hold while idle",
           {open_flag, short_flag}, 16'h4444);
    set_fixture('0, 0, 0, 0, 0, 0, 1'b0);
    run(0, 0, 0, 1, '0, '0);
  endtask

  task automatic t_mid_start();
    set_fixture('0, 0, 0, 0, 0, 0, 1'b0);      // R8 strobe mid-run ignored
    run(0, 1, 0, 0, '0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_clean();
    t_open();
    t_short();
    t_stuck_hi();
    t_stuck_lo_done_start();
    t_hold_then_clear();
    t_mid_start();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule